// File: doc/BRIEF.md
# Double-Buffered Video Memory Frame Synchronizer

This block holds two copies of the video memory. A renderer reads its own copy through a read port with one cycle of latency, and a host fills the other copy through a write port with a valid/ready handshake. When the host has finished a frame, it pulses `host_frame_done`. At the next `blank_start` strobe the block copies the whole host-side memory into the renderer-side memory. In the same step it moves a small bank of shadowed control words, such as scroll offsets, into their live registers. The renderer therefore never sees a partial frame or a scroll change in the middle of a frame.

Each memory is divided into segments that are copied in parallel. Inside each segment both ports of the renderer-side array are written on every copy cycle, so a segment of `SEG_DEPTH` words takes `SEG_DEPTH/2` cycles. If the host is not ready at blank start, the renderer keeps the previous frame. If the blanking budget given on `cfg_budget` is too short for the copy, no copy is made and a sticky overrun flag is raised. The pending frame is kept, so it is copied at a later blank.

Top module: `vram_frame_sync`

## Requirements
- R1: While reset is held and after it is released, `frame_pending`, `copy_busy`, `sync_done` and `overrun` are 0, `host_wr_ready` is 1, and `ctl_active` is all zeros.
- R2: A one-cycle pulse on `host_frame_done` sets `frame_pending`. The flag stays set until a copy completes.
- R3: A `blank_start` that arrives while `frame_pending` is 1, no copy is running and `cfg_budget` is at least SEG_DEPTH/2 starts a copy. `copy_busy` is then high for exactly SEG_DEPTH/2 cycles, starting the cycle after the strobe. Afterwards every renderer-side address holds the host-side word at the same address.
- R4: A `blank_start` that arrives while `frame_pending` is 0 starts no copy and raises no `sync_done`. The renderer-side memory and `ctl_active` keep their previous values.
- R5: `host_wr_ready` is 0 while `copy_busy` is 1, and a write is taken only on a cycle where valid and ready are both 1. A write presented during a copy is held until the copy ends and is not part of that copy. It lands in host-side memory and appears in the renderer-side memory after the next sync.
- R6: A write with `host_wr_ctl`=1 stores `host_wr_data` in the shadow control word whose index is the low bits of `host_wr_addr` (word k occupies `ctl_active[k*DATA_W +: DATA_W]`). `ctl_active` changes only in the cycle in which `sync_done` is high, and it then takes all the shadow values together.
- R7: `sync_done` is high for exactly one cycle, in the cycle after the last copy cycle. In that same cycle `frame_pending` reads 0.
- R8: A `blank_start` that arrives while a frame is pending and `cfg_budget` is below SEG_DEPTH/2 starts no copy. It sets `overrun`, which stays set until reset, and it leaves `frame_pending` set. A budget exactly equal to SEG_DEPTH/2 is enough for a copy.
- R9: `rnd_data` presents the renderer-side word addressed by `rnd_addr` one cycle after that address is applied. Address bits above log2(SEG_DEPTH) select the segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr_valid | input | 1 | Host write request |
| host_wr_ready | output | 1 | Write can be taken this cycle (low during a copy) |
| host_wr_ctl | input | 1 | 1 = write a shadow control word, 0 = write memory |
| host_wr_addr | input | ADDR_W | Memory address {segment, word}, or control-word index in the low bits |
| host_wr_data | input | DATA_W | Write data |
| host_frame_done | input | 1 | Host finished its frame (pulse) |
| frame_pending | output | 1 | A finished host frame waits for a blank |
| blank_start | input | 1 | Strobe at the start of vertical blanking |
| cfg_budget | input | BUDGET_W | Cycles available for the copy in this blank |
| rnd_addr | input | ADDR_W | Renderer read address |
| rnd_data | output | DATA_W | Renderer read data, one cycle later |
| ctl_active | output | NREGS*DATA_W | Live control words seen by the renderer |
| copy_busy | output | 1 | Copy in progress |
| sync_done | output | 1 | One-cycle pulse when the copy and the control commit have finished |
| overrun | output | 1 | Sticky: a copy was refused because the budget was too short |

## Verification
The hardest case to reach from the ports is a host write that collides with a running copy. The write must be held back and must not land in the frame being copied, yet it must not be lost. The bench raises `blank_start` with a frame pending and then presents a write on the very next cycle. It counts the cycles during which ready stays low. It then reads the renderer copy of that address to confirm that the old word was copied, runs a second sync, and confirms that the new word arrives. The overrun path is reached by giving a budget one cycle below the copy length. That stimulus is followed by a budget exactly equal to the copy length, which confirms that the pending frame is copied at the boundary.

// File: rtl/vsync_pkg.sv
package vsync_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_COPY = 1'b1
  } phase_e;
endpackage

// File: rtl/vsync_seg_mem.sv
// One memory segment: host-side array and renderer-side array.
// A copy step moves one even/odd word pair on both renderer write ports.
module vsync_seg_mem #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW - 1
) (
  input  logic              clk,
  input  logic              hw_en,
  input  logic [AW-1:0]     hw_addr,
  input  logic [DATA_W-1:0] hw_data,
  input  logic              cp_en,
  input  logic [PW-1:0]     cp_pair,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] host_arr [DEPTH];
  logic [DATA_W-1:0] rend_arr [DEPTH];
  logic [AW-1:0]     idx_even;
  logic [AW-1:0]     idx_odd;

  assign idx_even = {cp_pair, 1'b0};
  assign idx_odd  = {cp_pair, 1'b1};

  always_ff @(posedge clk) begin
    if (hw_en) begin
      host_arr[hw_addr] <= hw_data;
    end
  end

  always_ff @(posedge clk) begin
    if (cp_en) begin
      rend_arr[idx_even] <= host_arr[idx_even];
      rend_arr[idx_odd]  <= host_arr[idx_odd];
    end
  end

  assign rd_data = rend_arr[rd_addr];
endmodule

// File: rtl/vsync_copy_ctrl.sv
// Sequencer: samples the frame-ready flag at blank start, checks the budget,
// steps the pair index and issues the commit and done strobes.
module vsync_copy_ctrl
  import vsync_pkg::*;
#(
  parameter int PAIRS    = 4,
  parameter int BUDGET_W = 8,
  localparam int PW      = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                blank_start,
  input  logic                host_frame_done,
  input  logic [BUDGET_W-1:0] cfg_budget,
  output logic                busy,
  output logic [PW-1:0]       pair,
  output logic                commit,
  output logic                sync_done,
  output logic                frame_pending,
  output logic                overrun
);
  phase_e        phase_q, phase_d;
  logic [PW-1:0] pair_q, pair_d;
  logic          pend_q, pend_d;
  logic          done_q, done_d;
  logic          ovr_q, ovr_d;
  logic          fits, try_start, go, refuse, last;

  assign busy      = (phase_q == PH_COPY);
  assign fits      = (32'(cfg_budget) >= PAIRS);
  assign try_start = blank_start && pend_q && !busy;
  assign go        = try_start && fits;
  assign refuse    = try_start && !fits;
  assign last      = busy && (pair_q == PW'(PAIRS - 1));

  always_comb begin
    phase_d = phase_q;
    pair_d  = pair_q;
    if (go) begin
      phase_d = PH_COPY;
      pair_d  = '0;
    end else if (last) begin
      phase_d = PH_IDLE;
    end else if (busy) begin
      pair_d  = pair_q + PW'(1);
    end
    pend_d = host_frame_done ? 1'b1 : (last ? 1'b0 : pend_q);
    done_d = last;
    ovr_d  = ovr_q | refuse;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      pair_q  <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pair_q  <= pair_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
      ovr_q   <= ovr_d;
    end
  end

  assign pair          = pair_q;
  assign commit        = last;
  assign sync_done     = done_q;
  assign frame_pending = pend_q;
  assign overrun       = ovr_q;
endmodule

// File: rtl/vsync_ctl_regs.sv
// Shadow control words written by the host, moved to the live set on commit.
module vsync_ctl_regs #(
  parameter int NREGS  = 2,
  parameter int DATA_W = 16,
  localparam int IW    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    wr_en,
  input  logic [IW-1:0]           wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    commit,
  output logic [NREGS*DATA_W-1:0] ctl_active
);
  for (genvar k = 0; k < NREGS; k++) begin : g_word
    logic [DATA_W-1:0] shadow_q, shadow_d;
    logic [DATA_W-1:0] live_q, live_d;

    always_comb begin
      shadow_d = (wr_en && (wr_idx == IW'(k))) ? wr_data : shadow_q;
      live_d   = commit ? shadow_q : live_q;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
        live_q   <= '0;
      end else begin
        shadow_q <= shadow_d;
        live_q   <= live_d;
      end
    end

    assign ctl_active[k*DATA_W +: DATA_W] = live_q;
  end
endmodule

// File: rtl/vram_frame_sync.sv
module vram_frame_sync #(
  parameter int  SEGS      = 4,
  parameter int  SEG_DEPTH = 8,
  parameter int  DATA_W    = 16,
  parameter int  NREGS     = 2,
  parameter int  BUDGET_W  = 8,
  localparam int SEG_AW    = $clog2(SEG_DEPTH),
  localparam int SEL_W     = $clog2(SEGS),
  localparam int ADDR_W    = SEG_AW + SEL_W,
  localparam int PAIRS     = SEG_DEPTH / 2,
  localparam int PW        = SEG_AW - 1,
  localparam int REG_IW    = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int CTL_W     = NREGS * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr_valid,
  output logic                host_wr_ready,
  input  logic                host_wr_ctl,
  input  logic [ADDR_W-1:0]   host_wr_addr,
  input  logic [DATA_W-1:0]   host_wr_data,
  input  logic                host_frame_done,
  output logic                frame_pending,
  input  logic                blank_start,
  input  logic [BUDGET_W-1:0] cfg_budget,
  input  logic [ADDR_W-1:0]   rnd_addr,
  output logic [DATA_W-1:0]   rnd_data,
  output logic [CTL_W-1:0]    ctl_active,
  output logic                copy_busy,
  output logic                sync_done,
  output logic                overrun
);
  logic [1:0]        rst_pipe;
  logic              rst_ni;
  logic              wr_fire, mem_fire, ctl_fire, commit;
  logic [PW-1:0]     cp_pair;
  logic [DATA_W-1:0] seg_rd [SEGS];
  logic [DATA_W-1:0] rnd_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  assign host_wr_ready = !copy_busy;
  assign wr_fire       = host_wr_valid && host_wr_ready;
  assign mem_fire      = wr_fire && !host_wr_ctl;
  assign ctl_fire      = wr_fire && host_wr_ctl;

  vsync_copy_ctrl #(.PAIRS(PAIRS), .BUDGET_W(BUDGET_W)) u_ctrl (
    .clk             (clk),
    .rst_ni          (rst_ni),
    .blank_start     (blank_start),
    .host_frame_done (host_frame_done),
    .cfg_budget      (cfg_budget),
    .busy            (copy_busy),
    .pair            (cp_pair),
    .commit          (commit),
    .sync_done       (sync_done),
    .frame_pending   (frame_pending),
    .overrun         (overrun)
  );

  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    vsync_seg_mem #(.DEPTH(SEG_DEPTH), .DATA_W(DATA_W)) u_seg (
      .clk     (clk),
      .hw_en   (mem_fire && (host_wr_addr[ADDR_W-1:SEG_AW] == SEL_W'(g))),
      .hw_addr (host_wr_addr[SEG_AW-1:0]),
      .hw_data (host_wr_data),
      .cp_en   (copy_busy),
      .cp_pair (cp_pair),
      .rd_addr (rnd_addr[SEG_AW-1:0]),
      .rd_data (seg_rd[g])
    );
  end

  vsync_ctl_regs #(.NREGS(NREGS), .DATA_W(DATA_W)) u_ctl (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .wr_en      (ctl_fire),
    .wr_idx     (host_wr_addr[REG_IW-1:0]),
    .wr_data    (host_wr_data),
    .commit     (commit),
    .ctl_active (ctl_active)
  );

  always_ff @(posedge clk) begin
    rnd_q <= seg_rd[rnd_addr[ADDR_W-1:SEG_AW]];
  end
  assign rnd_data = rnd_q;
endmodule

// File: rtl/vram_frame_sync_chk.sv
module vram_frame_sync_chk #(
  parameter int PAIRS    = 4,
  parameter int CTL_W    = 32,
  parameter int BUDGET_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                blank_start,
  input logic                frame_pending,
  input logic [BUDGET_W-1:0] cfg_budget,
  input logic                host_wr_ready,
  input logic                copy_busy,
  input logic                sync_done,
  input logic                overrun,
  input logic [CTL_W-1:0]    ctl_active
);
  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= '0;
    else if (copy_busy) run_len <= run_len + 8'd1;
    else                run_len <= '0;
  end

  p_copy_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_start && frame_pending && !copy_busy && (32'(cfg_budget) >= PAIRS)) |=> copy_busy);

  p_copy_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(copy_busy) |-> (32'(run_len) == PAIRS));

  p_idle_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_start && !frame_pending && !copy_busy) |=> !copy_busy);

  p_stall_in_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    copy_busy |-> !host_wr_ready);

  p_ctl_only_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_done |-> $stable(ctl_active));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |=> !sync_done);

  p_done_follows_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> ($past(copy_busy) && !copy_busy && !frame_pending));

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_short_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_start && frame_pending && !copy_busy && (32'(cfg_budget) < PAIRS)) |=> (!copy_busy && overrun));
endmodule

bind vram_frame_sync vram_frame_sync_chk #(
  .PAIRS    (SEG_DEPTH / 2),
  .CTL_W    (NREGS * DATA_W),
  .BUDGET_W (BUDGET_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .blank_start   (blank_start),
  .frame_pending (frame_pending),
  .cfg_budget    (cfg_budget),
  .host_wr_ready (host_wr_ready),
  .copy_busy     (copy_busy),
  .sync_done     (sync_done),
  .overrun       (overrun),
  .ctl_active    (ctl_active)
);

// File: tb/vram_frame_sync_bench.sv
module vram_frame_sync_bench;
  localparam int SEGS      = 4;
  localparam int SEG_DEPTH = 8;
  localparam int DATA_W    = 16;
  localparam int NREGS     = 2;
  localparam int BUDGET_W  = 8;
  localparam int ADDR_W    = $clog2(SEGS) + $clog2(SEG_DEPTH);
  localparam int WORDS     = SEGS * SEG_DEPTH;
  localparam int PAIRS     = SEG_DEPTH / 2;
  localparam int NVEC      = 6;
  // {address, data}: touches every segment, even and odd words
  localparam logic [ADDR_W+DATA_W-1:0] VEC [NVEC] = '{
    {5'd0,  16'h1234}, {5'd9,  16'h5678}, {5'd18, 16'h9ABC},
    {5'd27, 16'hDEF0}, {5'd31, 16'h0F0F}, {5'd12, 16'hC3C3}
  };

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 wr_valid, wr_ready, wr_ctl;
  logic [ADDR_W-1:0]    wr_addr, rnd_addr;
  logic [DATA_W-1:0]    wr_data, rnd_data;
  logic                 frame_done, frame_pending, blank_start;
  logic [BUDGET_W-1:0]  cfg_budget;
  logic [NREGS*DATA_W-1:0] ctl_active;
  logic                 copy_busy, sync_done, overrun;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [DATA_W-1:0] hm [WORDS];
  logic [DATA_W-1:0] rm [WORDS];
  logic [DATA_W-1:0] sh [NREGS];
  logic [DATA_W-1:0] act [NREGS];

  always #10 clk = ~clk;

  vram_frame_sync #(
    .SEGS(SEGS), .SEG_DEPTH(SEG_DEPTH), .DATA_W(DATA_W),
    .NREGS(NREGS), .BUDGET_W(BUDGET_W)
  ) u_vram_frame_sync (
    .clk(clk), .rst_n(rst_n),
    .host_wr_valid(wr_valid), .host_wr_ready(wr_ready), .host_wr_ctl(wr_ctl),
    .host_wr_addr(wr_addr), .host_wr_data(wr_data),
    .host_frame_done(frame_done), .frame_pending(frame_pending),
    .blank_start(blank_start), .cfg_budget(cfg_budget),
    .rnd_addr(rnd_addr), .rnd_data(rnd_data), .ctl_active(ctl_active),
    .copy_busy(copy_busy), .sync_done(sync_done), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [63:0] actual, input logic [63:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  function automatic logic [NREGS*DATA_W-1:0] live_exp();
    logic [NREGS*DATA_W-1:0] v;
    for (int k = 0; k < NREGS; k++) v[k*DATA_W +: DATA_W] = act[k];
    return v;
  endfunction

  task automatic host_write(input logic ctl, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d, output int stalls);
    @(negedge clk);
    wr_valid = 1'b1; wr_ctl = ctl; wr_addr = a; wr_data = d;
    stalls = 0;
    while (!wr_ready && stalls < 100) begin
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0; wr_ctl = 1'b0;
    if (ctl) sh[a % NREGS] = d;
    else     hm[a] = d;
  endtask

  task automatic pulse_done();
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
  endtask

  task automatic do_sync(input logic [BUDGET_W-1:0] bud, input bit expect_copy, input string req);
    int n;
    @(negedge clk); blank_start = 1'b1; cfg_budget = bud;
    @(negedge clk); blank_start = 1'b0;
    n = 0;
    while (copy_busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    if (expect_copy) begin
      chk({req, " copy length"}, 64'(n), 64'(PAIRS));
      chk("R7 sync_done high after copy", 64'(sync_done), 64'd1);
      chk("R7 frame_pending cleared", 64'(frame_pending), 64'd0);
      for (int a = 0; a < WORDS; a++) rm[a] = hm[a];
      for (int k = 0; k < NREGS; k++) act[k] = sh[k];
      chk("R6 ctl commit with sync_done", 64'(ctl_active), 64'(live_exp()));
      @(negedge clk);
      chk("R7 sync_done one cycle", 64'(sync_done), 64'd0);
    end else begin
      chk({req, " no copy"}, 64'(n), 64'd0);
      chk({req, " no sync_done"}, 64'(sync_done), 64'd0);
    end
  endtask

  task automatic read_one(input string req, input int a);
    @(negedge clk); rnd_addr = ADDR_W'(a);
    @(negedge clk);
    chk(req, 64'(rnd_data), 64'(rm[a]));
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < WORDS; a++) read_one(req, a);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int st;
    rst_n = 1'b0; wr_valid = 1'b0; wr_ctl = 1'b0; wr_addr = '0; wr_data = '0;
    frame_done = 1'b0; blank_start = 1'b0; cfg_budget = 8'd20; rnd_addr = '0;
    for (int k = 0; k < NREGS; k++) begin sh[k] = '0; act[k] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 ready during reset", 64'(wr_ready), 64'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 frame_pending", 64'(frame_pending), 64'd0);
    chk("R1 copy_busy", 64'(copy_busy), 64'd0);
    chk("R1 sync_done", 64'(sync_done), 64'd0);
    chk("R1 overrun", 64'(overrun), 64'd0);
    chk("R1 host_wr_ready", 64'(wr_ready), 64'd1);
    chk("R1 ctl_active", 64'(ctl_active), 64'd0);

    // first full frame
    for (int a = 0; a < WORDS; a++) host_write(1'b0, ADDR_W'(a), 16'hA000 ^ DATA_W'(a * 37), st);
    host_write(1'b1, 5'd0, 16'h1111, st);
    host_write(1'b1, 5'd1, 16'h2222, st);
    chk("R6 shadow write leaves ctl_active", 64'(ctl_active), 64'd0);
    pulse_done();
    chk("R2 pending set", 64'(frame_pending), 64'd1);
    repeat (2) @(negedge clk);
    chk("R2 pending held", 64'(frame_pending), 64'd1);
    do_sync(8'd20, 1'b1, "R3");
    read_all("R3 R9 renderer copy");

    // vector table: a skipped blank keeps the old frame, a ready blank copies
    for (int i = 0; i < NVEC; i++) begin
      host_write(1'b0, VEC[i][ADDR_W+DATA_W-1:DATA_W], VEC[i][DATA_W-1:0], st);
      do_sync(8'd20, 1'b0, "R4");
      read_one("R4 old word kept", int'(VEC[i][ADDR_W+DATA_W-1:DATA_W]));
      chk("R4 ctl unchanged", 64'(ctl_active), 64'(live_exp()));
      pulse_done();
      do_sync(8'd20, 1'b1, "R3");
      read_one("R3 new word copied", int'(VEC[i][ADDR_W+DATA_W-1:DATA_W]));
    end

    // R5: write collides with a copy
    pulse_done();
    @(negedge clk); blank_start = 1'b1; cfg_budget = 8'd20;
    @(negedge clk); blank_start = 1'b0;
    chk("R5 ready low in copy", 64'(wr_ready), 64'd0);
    for (int a = 0; a < WORDS; a++) rm[a] = hm[a];
    for (int k = 0; k < NREGS; k++) act[k] = sh[k];
    host_write(1'b0, 5'd7, 16'hBEEF, st);
    chk("R5 stall cycles", 64'(st), 64'(PAIRS - 1));
    read_one("R5 stalled write not in copy", 7);
    pulse_done();
    do_sync(8'd20, 1'b1, "R5");
    read_one("R5 stalled write lands later", 7);

    // R8: budget too short, then exact
    host_write(1'b1, 5'd0, 16'h5A5A, st);
    pulse_done();
    do_sync(8'(PAIRS - 1), 1'b0, "R8");
    chk("R8 overrun set", 64'(overrun), 64'd1);
    chk("R8 pending kept", 64'(frame_pending), 64'd1);
    chk("R8 ctl unchanged", 64'(ctl_active), 64'(live_exp()));
    repeat (5) @(negedge clk);
    chk("R8 overrun sticky", 64'(overrun), 64'd1);
    do_sync(8'(PAIRS), 1'b1, "R8 exact budget");
    chk("R8 overrun still set", 64'(overrun), 64'd1);
    read_all("R8 R3 copy after overrun");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule